// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Control Interface

This block is the device-side digital front of a converter that samples up to four channels at once. A host writes a 4-bit mode word over the low lines of a shared bidirectional bus. It then pulses a start strobe. The block runs a timed sequence that fills a four-entry result store, and it signals completion by pulling an active-low interrupt. The host then collects the results with read strobes. An internal pointer steps through the four entries and wraps back to the first one.

The conversion itself is replaced by a synthesizable stand-in. Two test input ports, one for each input group, carry one packed value per channel. The values of the selected group are captured on the start edge and stored one channel per time slot. A slot lasts two microseconds, counted in system clock cycles.

All strobes are active low. They are sampled on the system clock and are expected to be synchronous to it already.

Top module: `sadc_top`

## Requirements
- R1: A mode word is taken from bus bits [3:0] while chip-select and write are both low. It becomes active on the first clock after either strobe returns high, and it stays in force until the next write.
- R2: Mode word encoding: bits [1:0] hold the channel count minus one (0 gives 1 channel, 3 gives 4). Bit 2 picks input group B when 1 and group A when 0. Bit 3 set to 1 requests power-down.
- R3: After reset the interrupt is high and busy is low. The mode is group A with one channel.
- R4: A conversion starts on the clock where the start strobe is seen high after being low. The test inputs of the selected group are captured at that point. Busy then stays high for exactly 2*CYC_PER_US*N cycles, where N is the programmed channel count.
- R5: The interrupt falls only on the clock where busy falls, after the last programmed channel has been stored. Channel k of the sequence stores the captured value of input k.
- R6: The first read falling edge while chip-select is low puts the entry of channel 1 on the bus and returns the interrupt high.
- R7: Each read rising edge while chip-select is low advances the read pointer by one. After four reads the pointer is back at channel 1, whatever the channel count.
- R8: Any rising edge of the start strobe returns the read pointer to channel 1.
- R9: While powered down, start pulses are ignored. A write with bit 3 at 0 wakes the block in the mode given by bits [2:0].
- R10: A start edge that arrives while busy is high does not lengthen or restart the running sequence.
- R11: The bus is driven with the entry selected by the read pointer only while chip-select and read are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip-select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cnv_n | input | 1 | Conversion start strobe; a sequence begins on its rising edge |
| dbus | inout | RES_W | Shared bus: mode word in on bits [3:0], results out; high impedance when not reading |
| int_n | output | 1 | End-of-sequence interrupt, active low |
| busy | output | 1 | High while a sequence runs |
| smp_a | input | 4*RES_W | Stand-in values for group A, channel k in bits [k*RES_W +: RES_W] |
| smp_b | input | 4*RES_W | Stand-in values for group B, same packing |

## Verification
The assertions assume the host follows the interface rules. It never writes a mode word while a sequence runs. It never reads during a sequence. It does not hold chip-select and write low together with read. Every strobe is steady for at least one clock. The stimulus keeps to this by driving one strobe change per falling clock edge. It only writes or reads after the interrupt has fallen, or while the block is idle. The one deliberate violation is a start pulse sent into a running sequence, which is there to show that it is ignored.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
   localparam int CH_MAX   = 4;
   localparam int CH_SEL_W = 2;
   localparam int CTL_W    = 4;

   typedef struct packed {
      logic                pwr_dn;
      logic                grp_b;
      logic [CH_SEL_W-1:0] last_ch;
   } mode_t;

   localparam mode_t MODE_RESET = '{pwr_dn: 1'b0, grp_b: 1'b0, last_ch: '0};
endpackage

// File: rtl/sadc_ctl.sv
module sadc_ctl
   import sadc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             wr_n,
   input  logic [CTL_W-1:0] wdata,
   output mode_t            mode
);
   logic [CTL_W-1:0] shadow;
   logic             pend;
   logic             wr_act;

   assign wr_act = ~cs_n & ~wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         pend   <= 1'b0;
         mode   <= MODE_RESET;
      end else if (wr_act) begin
         shadow <= wdata;
         pend   <= 1'b1;
      end else if (pend) begin
         pend <= 1'b0;
         if (shadow[3]) begin
            mode.pwr_dn <= 1'b1;
         end else begin
            mode <= '{pwr_dn: 1'b0, grp_b: shadow[2], last_ch: shadow[1:0]};
         end
      end
   end
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
   import sadc_pkg::*;
#(
   parameter int RES_W      = 12,
   parameter int CYC_PER_US = 50,
   localparam int SLOT      = 2 * CYC_PER_US,
   localparam int CNT_W     = (SLOT > 1) ? $clog2(SLOT) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic                          int_clr,
   input  mode_t                         mode,
   input  logic [CH_MAX*RES_W-1:0]       smp_a,
   input  logic [CH_MAX*RES_W-1:0]       smp_b,
   output logic                          busy,
   output logic                          int_n,
   output logic [CH_MAX-1:0][RES_W-1:0]  res
);
   logic [CH_MAX-1:0][RES_W-1:0] hold;
   logic [CH_MAX-1:0][RES_W-1:0] pick;
   logic [CNT_W-1:0]             cnt;
   logic [CH_SEL_W-1:0]          ch;
   logic                         slot_end;

   for (genvar k = 0; k < CH_MAX; k++) begin : g_pick
      assign pick[k] = mode.grp_b ? smp_b[k*RES_W +: RES_W] : smp_a[k*RES_W +: RES_W];
   end

   assign slot_end = (cnt == CNT_W'(SLOT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         int_n <= 1'b1;
         cnt   <= '0;
         ch    <= '0;
         hold  <= '0;
         res   <= '0;
      end else begin
         if (int_clr) int_n <= 1'b1;
         if (start && !busy && !mode.pwr_dn) begin
            busy <= 1'b1;
            cnt  <= '0;
            ch   <= '0;
            hold <= pick;
         end else if (busy) begin
            if (slot_end) begin
               cnt     <= '0;
               res[ch] <= hold[ch];
               if (ch == mode.last_ch) begin
                  busy  <= 1'b0;
                  int_n <= 1'b0;
               end else begin
                  ch <= ch + 1'b1;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sadc_rdp.sv
module sadc_rdp
   import sadc_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                rd_n,
   input  logic                clr,
   output logic                rd_fall,
   output logic [CH_SEL_W-1:0] ptr
);
   logic rd_q;
   logic rd_rise;

   assign rd_fall = rd_q & ~rd_n & ~cs_n;
   assign rd_rise = ~rd_q & rd_n & ~cs_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b1;
         ptr  <= '0;
      end else begin
         rd_q <= rd_n;
         if (clr) begin
            ptr <= '0;
         end else if (rd_rise) begin
            ptr <= (ptr == CH_SEL_W'(CH_MAX - 1)) ? '0 : ptr + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sadc_top.sv
module sadc_top
   import sadc_pkg::*;
#(
   parameter int RES_W      = 12,
   parameter int CYC_PER_US = 50
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_n,
   input  logic                    wr_n,
   input  logic                    rd_n,
   input  logic                    cnv_n,
   inout  wire  [RES_W-1:0]        dbus,
   output logic                    int_n,
   output logic                    busy,
   input  logic [CH_MAX*RES_W-1:0] smp_a,
   input  logic [CH_MAX*RES_W-1:0] smp_b
);
   if (RES_W < CTL_W) begin : g_bad_width
      $error("RES_W must be at least the mode word width");
   end
   if (CYC_PER_US < 1) begin : g_bad_rate
      $error("CYC_PER_US must be positive");
   end

   mode_t                        mode_q;
   logic                         cnv_q;
   logic                         cnv_rise;
   logic                         rd_fall;
   logic [CH_SEL_W-1:0]          rd_ptr;
   logic [CH_MAX-1:0][RES_W-1:0] res;
   logic                         pwr_dn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnv_q <= 1'b1;
      else        cnv_q <= cnv_n;
   end
   assign cnv_rise = ~cnv_q & cnv_n;
   assign pwr_dn   = mode_q.pwr_dn;

   sadc_ctl u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .wr_n  (wr_n),
      .wdata (dbus[CTL_W-1:0]),
      .mode  (mode_q)
   );

   sadc_seq #(.RES_W(RES_W), .CYC_PER_US(CYC_PER_US)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (cnv_rise),
      .int_clr (rd_fall),
      .mode    (mode_q),
      .smp_a   (smp_a),
      .smp_b   (smp_b),
      .busy    (busy),
      .int_n   (int_n),
      .res     (res)
   );

   sadc_rdp u_rdp (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .rd_n    (rd_n),
      .clr     (cnv_rise),
      .rd_fall (rd_fall),
      .ptr     (rd_ptr)
   );

   assign dbus = (!cs_n && !rd_n) ? res[rd_ptr] : 'z;
endmodule

// File: rtl/sadc_chk.sv
module sadc_chk #(
   parameter int SLOT  = 100,
   parameter int PTR_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             rd_n,
   input logic             cnv_n,
   input logic             busy,
   input logic             int_n,
   input logic             pwr_dn,
   input logic [PTR_W-1:0] ptr
);
   localparam int MAX_RUN = 4 * SLOT;
   int unsigned run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= 0;
      else if (busy) run_cnt <= run_cnt + 1;
      else           run_cnt <= 0;
   end

   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cnv_n) && !$past(cnv_n, 2)));                       // R4
   AST_INT_FALL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(int_n) |-> ($past(busy) && !busy));                                  // R5
   AST_INT_SET_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_n) |-> ($past(!rd_n) && $past(!cs_n)));                          // R6
   AST_PTR_CLR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (cnv_n && !$past(cnv_n)) |=> (ptr == '0));                                 // R8
   AST_NO_START_POWERED_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(pwr_dn));                                           // R9
   AST_BUSY_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt < MAX_RUN));                                             // R10
endmodule

bind sadc_top sadc_chk #(.SLOT(2 * CYC_PER_US), .PTR_W(sadc_pkg::CH_SEL_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_n   (cs_n),
   .rd_n   (rd_n),
   .cnv_n  (cnv_n),
   .busy   (busy),
   .int_n  (int_n),
   .pwr_dn (pwr_dn),
   .ptr    (rd_ptr)
);

// File: tb/test_sadc_top.sv
module test_sadc_top;
   localparam int RW   = 12;
   localparam int CPU  = 50;
   localparam int SLOT = 2 * CPU;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, cnv_n = 1'b1;
   logic tb_drv = 1'b0;
   logic [RW-1:0] tb_val = '0;
   logic [4*RW-1:0] smp_a = '0, smp_b = '0;
   wire  [RW-1:0] dbus;
   logic int_n, busy;
   int errors = 0, checks = 0;

   assign dbus = tb_drv ? tb_val : 'z;
   always #10 clk = ~clk;

   sadc_top #(.RES_W(RW), .CYC_PER_US(CPU)) i_sadc_top (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .cnv_n(cnv_n), .dbus(dbus), .int_n(int_n), .busy(busy),
      .smp_a(smp_a), .smp_b(smp_b)
   );

   function automatic logic [RW-1:0] val(int r, int m, int c);
      return RW'((r * 389 + m * 1511 + c * 677 + 91) % 4096);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load(int r);
      for (int c = 0; c < 4; c++) begin
         smp_a[c*RW +: RW] = val(r, 0, c);
         smp_b[c*RW +: RW] = val(r, 1, c);
      end
   endtask

   task automatic write_ctl(logic [3:0] w);
      @(negedge clk); cs_n = 1'b0; tb_drv = 1'b1; tb_val = RW'(w);
      @(negedge clk); wr_n = 1'b0;
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); cs_n = 1'b1; tb_drv = 1'b0;
   endtask

   task automatic pulse_cnv();
      @(negedge clk); cnv_n = 1'b0;
      @(negedge clk); cnv_n = 1'b1;
   endtask

   // returns the number of falling edges until int_n is seen low
   task automatic run_seq(bit mid_pulse, output int k);
      k = 0;
      pulse_cnv();
      do begin
         @(negedge clk); k++;
         if (mid_pulse && k == 10) cnv_n = 1'b0;
         if (mid_pulse && k == 11) cnv_n = 1'b1;
      end while (int_n && k < 5 * SLOT);
   endtask

   task automatic read_one(output logic [RW-1:0] d, output logic irq);
      @(negedge clk); cs_n = 1'b0;
      @(negedge clk); rd_n = 1'b0;
      @(negedge clk); d = dbus; irq = int_n; rd_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int k;
      int r;
      logic [RW-1:0] d;
      logic irq;
      r = 0;
      load(r);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3 int after reset", int_n, 1);
      check("R3 busy after reset", busy, 0);

      // R3: default mode is one channel of group A
      run_seq(1'b0, k);
      check("R3 R4 default length", k, SLOT + 1);
      read_one(d, irq);
      check("R3 R5 default value", d, val(r, 0, 0));
      check("R6 int cleared by read", irq, 1);

      // R1 R2: sweep group and channel count
      for (int m = 0; m < 2; m++) begin
         for (int n = 1; n <= 4; n++) begin
            logic [RW-1:0] first;
            r++;
            load(r);
            write_ctl({1'b0, m[0], 2'(n - 1)});
            // R10: a start pulse inside one run must not change its length
            run_seq(m == 1 && n == 3, k);
            check("R4 R10 sequence length", k, n * SLOT + 1);
            check("R5 int low at end", int_n, 0);
            for (int c = 0; c < 4; c++) begin
               read_one(d, irq);
               if (c == 0) begin
                  first = d;
                  check("R6 int high after first read", irq, 1);
               end
               // R8: previous run left pointer elsewhere, start must reset it
               if (c < n) check("R2 R5 R8 result value", d, val(r, m, c));
            end
            read_one(d, irq);
            check("R7 pointer wraps after four reads", d, first);
         end
      end

      // R9: power-down ignores start, then wake into two channels of group B
      write_ctl(4'b1000);
      pulse_cnv();
      k = 0;
      repeat (3 * SLOT) begin
         @(negedge clk);
         if (busy) k++;
      end
      check("R9 start ignored while powered down", k, 0);
      check("R9 int unchanged while powered down", int_n, 1);
      r++;
      load(r);
      write_ctl(4'b0101);
      run_seq(1'b0, k);
      check("R9 wake mode length", k, 2 * SLOT + 1);
      read_one(d, irq);
      check("R9 R11 wake ch1", d, val(r, 1, 0));
      read_one(d, irq);
      check("R9 R11 wake ch2", d, val(r, 1, 1));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule